// File: doc/BRIEF.md
# Cascadable Presettable Four-Bit Counter

A four-bit synchronous up counter with a parallel preset, an active-low clear and two count enables. Two compile-time parameters pick the variant. `IS_DECADE` selects modulo-16 binary counting or modulo-10 BCD counting. `ASYNC_CLEAR` selects a clear that zeroes the register at once, or a clear that acts on the next rising clock edge. The block has no data stream of its own. Every pin is a plain control or status pin, so no valid/ready handshake and no back-pressure rules apply.

The terminal-count output `carry` is gated only by `en_t`. Wider counters are built by feeding one stage's `carry` into the next stage's `en_t` and sharing `en_p` across all stages. Each stage then learns that it may count directly from the stage below, so no extra gates are needed. In the asynchronous variant, the release of the clear is retimed through a short synchronizer. Because of this, the counter cannot take a half-resolved first step when the clear rises near a clock edge.

Top module: `cnt4_cascadable`

## Requirements
- R1: With `ASYNC_CLEAR=0`, `clr_n` low at a rising edge makes `q` 0 after that edge, whatever `load_n`, `en_p` and `en_t` are. Between edges, `q` does not change.
- R2: With `ASYNC_CLEAR=1`, `clr_n` low drives `q` to 0 at once, without a clock edge. After `clr_n` returns high, `q` stays 0 and ignores load and enables on the next `SYNC_STAGES` (default 2) rising edges. It acts normally from the edge after that.
- R3: When the clear is inactive and `load_n` is low at a rising edge, `q` takes `din` (bit 0 of `din` goes to bit 0 of `q`), whatever the two enables are.
- R4: Clear outranks load: with both `clr_n` and `load_n` low, the result is 0.
- R5: When clear and load are inactive, `q` advances by one at a rising edge only when `en_p` and `en_t` are both high. If either enable is low, `q` holds.
- R6: `carry` is high exactly when `en_t` is high and `q` is at the terminal count. `en_p` never changes `carry`.
- R7: With `IS_DECADE=0`, the terminal count is 15 (all ones), and counting goes from 15 to 0.
- R8: With `IS_DECADE=1`, the terminal decode is bit 0 and bit 3 both set (true for 9, 11, 13 and 15), and counting goes from 9 to 0.
- R9: With `IS_DECADE=1`, a loaded value from 10 to 15 still increments with four-bit wrap (15 goes to 0). The counter then follows the legal 0 to 9 sequence.
- R10: Two stages form a wider counter when the lower `carry` drives the upper `en_t` and `en_p` is shared. The result is an 8-bit binary counter or a two-digit BCD counter, and it keeps counting correctly after a preset in the middle of a count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Clear, active low; asynchronous or synchronous per `ASYNC_CLEAR` |
| load_n | input | 1 | Parallel preset, active low, synchronous |
| din | input | CNT_W | Preset value |
| en_p | input | 1 | Count enable that does not affect carry |
| en_t | input | 1 | Count enable that also gates carry |
| q | output | CNT_W | Counter state |
| carry | output | 1 | Terminal count qualified by `en_t` |

## Verification
The bench builds two cascaded pairs, one binary with a synchronous clear and one decade with an asynchronous clear. It drives both pairs with the same stimulus, so a single input pattern shows how the two variants differ. Long free-running counts check the wrap at 255 and at 99 across both stages. Runs with one enable held low separate the gating of `carry` from the gating of the count. The clear is dropped in the middle of a cycle: the decade pair must go to zero before the edge and the binary pair only at the edge, which tells the two clear styles apart. Presets with both enables low, a clear and a load together, an illegal decade preset, and a preset in the middle of a count cover the priority order, recovery from illegal states, and the cascade chain.

// File: rtl/cnt4_pkg.sv
package cnt4_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;

endpackage

// File: rtl/cnt4_ctrl.sv
module cnt4_ctrl
  import cnt4_pkg::*;
(
  input  logic    clr_act,
  input  logic    load_n,
  input  logic    en_p,
  input  logic    en_t,
  output cnt_op_e op
);

  // Clear first, then preset, then count; otherwise hold.
  always_comb begin
    if (clr_act)            op = OP_CLEAR;
    else if (!load_n)       op = OP_LOAD;
    else if (en_p && en_t)  op = OP_COUNT;
    else                    op = OP_HOLD;
  end

endmodule

// File: rtl/cnt4_next.sv
module cnt4_next
  import cnt4_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter bit IS_DECADE = 1'b0
) (
  input  cnt_op_e          op,
  input  logic [CNT_W-1:0] q,
  input  logic [CNT_W-1:0] din,
  output logic [CNT_W-1:0] d
);

  localparam logic [CNT_W-1:0] DEC_LAST = CNT_W'(9);

  logic [CNT_W-1:0] inc;

  generate
    if (IS_DECADE) begin : g_dec
      // Legal last digit wraps to zero; illegal codes use plain wrap.
      always_comb inc = (q == DEC_LAST) ? '0 : q + 1'b1;
    end else begin : g_bin
      always_comb inc = q + 1'b1;
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_CLEAR: d = '0;
      OP_LOAD:  d = din;
      OP_COUNT: d = inc;
      default:  d = q;
    endcase
  end

endmodule

// File: rtl/cnt4_tc.sv
module cnt4_tc #(
  parameter int CNT_W     = 4,
  parameter bit IS_DECADE = 1'b0
) (
  input  logic [CNT_W-1:0] q,
  input  logic             en_t,
  output logic             carry
);

  logic term;

  generate
    if (IS_DECADE) begin : g_dec
      always_comb term = q[0] & q[3];
    end else begin : g_bin
      always_comb term = &q;
    end
  endgenerate

  assign carry = en_t & term;

endmodule

// File: rtl/cnt4_rel_sync.sv
module cnt4_rel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic rel_n
);

  logic [STAGES-1:0] sh;

  // Assert at once, release only after STAGES rising edges.
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], 1'b1};
  end

  assign rel_n = sh[STAGES-1];

endmodule

// File: rtl/cnt4_cascadable.sv
module cnt4_cascadable
  import cnt4_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter bit IS_DECADE   = 1'b0,
  parameter bit ASYNC_CLEAR = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [CNT_W-1:0] din,
  input  logic             en_p,
  input  logic             en_t,
  output logic [CNT_W-1:0] q,
  output logic             carry
);

  logic             clr_ok;
  logic             clr_act;
  cnt_op_e          op;
  logic [CNT_W-1:0] d;

  generate
    if (ASYNC_CLEAR) begin : g_async
      cnt4_rel_sync #(.STAGES(SYNC_STAGES)) u_rel (
        .clk   (clk),
        .clr_n (clr_n),
        .rel_n (clr_ok)
      );
      assign clr_act = 1'b0;
      always_ff @(posedge clk or negedge clr_ok) begin
        if (!clr_ok) q <= '0;
        else         q <= d;
      end
    end else begin : g_sync
      assign clr_ok  = clr_n;
      assign clr_act = ~clr_n;
      always_ff @(posedge clk) q <= d;
    end
  endgenerate

  cnt4_ctrl u_ctrl (
    .clr_act (clr_act),
    .load_n  (load_n),
    .en_p    (en_p),
    .en_t    (en_t),
    .op      (op)
  );

  cnt4_next #(.CNT_W(CNT_W), .IS_DECADE(IS_DECADE)) u_next (
    .op  (op),
    .q   (q),
    .din (din),
    .d   (d)
  );

  cnt4_tc #(.CNT_W(CNT_W), .IS_DECADE(IS_DECADE)) u_tc (
    .q     (q),
    .en_t  (en_t),
    .carry (carry)
  );

endmodule

// File: rtl/cnt4_cascadable_chk.sv
module cnt4_cascadable_chk #(
  parameter int CNT_W       = 4,
  parameter bit IS_DECADE   = 1'b0,
  parameter bit ASYNC_CLEAR = 1'b0
) (
  input logic             clk,
  input logic             clr_n,
  input logic             clr_ok,
  input logic             load_n,
  input logic [CNT_W-1:0] din,
  input logic             en_p,
  input logic             en_t,
  input logic [CNT_W-1:0] q,
  input logic             carry
);

  generate
    if (ASYNC_CLEAR) begin : g_async
      a_r2_async_zero: assert property (@(posedge clk)
        !clr_n |-> (q == '0));
      a_r2_release_hold: assert property (@(posedge clk)
        !clr_ok |=> (q == '0));
    end else begin : g_sync
      a_r1_sync_clear: assert property (@(posedge clk)
        !clr_n |=> (q == '0));
    end
    if (IS_DECADE) begin : g_dec
      a_r8_legal_stays_legal: assert property (@(posedge clk) disable iff (!clr_n)
        (clr_ok && load_n && q <= CNT_W'(9)) |=> (q <= CNT_W'(9)));
    end else begin : g_bin
      a_r7_wrap: assert property (@(posedge clk) disable iff (!clr_n)
        (clr_ok && load_n && en_p && en_t && q == '1) |=> (q == '0));
    end
  endgenerate

  a_r3_preset: assert property (@(posedge clk) disable iff (!clr_n)
    (clr_ok && !load_n) |=> (q == $past(din)));

  a_r5_hold: assert property (@(posedge clk) disable iff (!clr_n)
    (clr_ok && load_n && !(en_p && en_t)) |=> $stable(q));

  a_r6_carry_needs_t: assert property (@(posedge clk) disable iff (!clr_n)
    carry |-> (en_t && q[0]));

  a_r6_no_t_no_carry: assert property (@(posedge clk) disable iff (!clr_n)
    !en_t |-> !carry);

endmodule

bind cnt4_cascadable cnt4_cascadable_chk #(
  .CNT_W       (CNT_W),
  .IS_DECADE   (IS_DECADE),
  .ASYNC_CLEAR (ASYNC_CLEAR)
) u_chk (
  .clk    (clk),
  .clr_n  (clr_n),
  .clr_ok (clr_ok),
  .load_n (load_n),
  .din    (din),
  .en_p   (en_p),
  .en_t   (en_t),
  .q      (q),
  .carry  (carry)
);

// File: tb/cnt4_cascadable_tb_top.sv
module cnt4_cascadable_tb_top;

  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       load_n = 1'b1;
  logic       en_p = 1'b0;
  logic       en_t_in = 1'b0;
  logic [3:0] din_lo = '0;
  logic [3:0] din_hi = '0;

  logic [3:0] a_q_lo, a_q_hi, b_q_lo, b_q_hi;
  logic       a_c_lo, a_c_hi, b_c_lo, b_c_hi;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int a_lo = 0, a_hi = 0, b_lo = 0, b_hi = 0, b_hold = 2;

  always #2 clk = ~clk;

  // Pair A: binary, synchronous clear
  cnt4_cascadable #(.IS_DECADE(1'b0), .ASYNC_CLEAR(1'b0)) dut_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din_lo),
    .en_p(en_p), .en_t(en_t_in), .q(a_q_lo), .carry(a_c_lo));
  cnt4_cascadable #(.IS_DECADE(1'b0), .ASYNC_CLEAR(1'b0)) dut_a_hi (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din_hi),
    .en_p(en_p), .en_t(a_c_lo), .q(a_q_hi), .carry(a_c_hi));
  // Pair B: decade, asynchronous clear
  cnt4_cascadable #(.IS_DECADE(1'b1), .ASYNC_CLEAR(1'b1)) dut_b_lo (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din_lo),
    .en_p(en_p), .en_t(en_t_in), .q(b_q_lo), .carry(b_c_lo));
  cnt4_cascadable #(.IS_DECADE(1'b1), .ASYNC_CLEAR(1'b1)) dut_b_hi (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din_hi),
    .en_p(en_p), .en_t(b_c_lo), .q(b_q_hi), .carry(b_c_hi));

  function automatic int dec_next(int v);
    return (v == 9) ? 0 : ((v + 1) % 16);
  endfunction

  function automatic bit dec_term(int v);
    return ((v & 9) == 9);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    bit eca, ecb;
    eca = en_t_in && (a_lo == 15);
    ecb = en_t_in && dec_term(b_lo);
    chk(tag, "A lo q", a_q_lo, a_lo);
    chk(tag, "A hi q", a_q_hi, a_hi);
    chk(tag, "B lo q", b_q_lo, b_lo);
    chk(tag, "B hi q", b_q_hi, b_hi);
    chk(tag, "A lo carry", a_c_lo, eca);
    chk(tag, "A hi carry", a_c_hi, eca && (a_hi == 15));
    chk(tag, "B lo carry", b_c_lo, ecb);
    chk(tag, "B hi carry", b_c_hi, ecb && dec_term(b_hi));
  endtask

  // One rising edge: update the expected values from the requirements, then compare.
  task automatic step(string tag);
    bit ca, cb;
    @(posedge clk);
    ca = en_t_in && (a_lo == 15);
    if (!clr_n) begin a_lo = 0; a_hi = 0; end
    else if (!load_n) begin a_lo = din_lo; a_hi = din_hi; end
    else if (en_p) begin
      if (en_t_in) a_lo = (a_lo + 1) % 16;
      if (ca) a_hi = (a_hi + 1) % 16;
    end
    cb = en_t_in && dec_term(b_lo);
    if (!clr_n) begin b_lo = 0; b_hi = 0; b_hold = 2; end
    else if (b_hold > 0) begin b_hold--; b_lo = 0; b_hi = 0; end
    else if (!load_n) begin b_lo = din_lo; b_hi = din_hi; end
    else if (en_p) begin
      if (en_t_in) b_lo = dec_next(b_lo);
      if (cb) b_hi = dec_next(b_hi);
    end
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic t_reset();
    step("R1 R2");
    step("R1 R2");
    clr_n = 1'b1;
    en_p = 1'b1; en_t_in = 1'b1; load_n = 1'b0; din_lo = 4'd3;
    step("R2");   // B still held after release
    step("R2");
    load_n = 1'b1; en_p = 1'b0; en_t_in = 1'b0;
    step("R2");
  endtask

  task automatic t_long_count();
    load_n = 1'b0; din_lo = 4'd0; din_hi = 4'd0;
    step("R3");
    load_n = 1'b1; en_p = 1'b1; en_t_in = 1'b1;
    for (int i = 0; i < 300; i++) step("R7 R8 R10");
  endtask

  task automatic t_enables();
    en_p = 1'b0; en_t_in = 1'b0; load_n = 1'b0; din_lo = 4'd15; din_hi = 4'd9;
    step("R3");
    load_n = 1'b1; en_t_in = 1'b1;
    step("R5 R6");   // P low: hold, carry still follows T
    step("R5 R6");
    en_p = 1'b1; en_t_in = 1'b0;
    step("R5 R6");   // T low: hold, carry low
    en_t_in = 1'b1;
    step("R5 R7");
    en_p = 1'b0; en_t_in = 1'b0;
  endtask

  task automatic t_priority();
    load_n = 1'b0; din_lo = 4'd5; din_hi = 4'd2;
    step("R3");
    @(negedge clk);
    clr_n = 1'b0; b_lo = 0; b_hi = 0; b_hold = 2;
    step("R4");
    clr_n = 1'b1; load_n = 1'b1;
    step("R2");
    step("R2");
    step("R2");
  endtask

  task automatic t_async();
    load_n = 1'b0; din_lo = 4'd3; din_hi = 4'd4;
    step("R3");
    load_n = 1'b1; en_p = 1'b1; en_t_in = 1'b1;
    step("R5");
    step("R5");
    clr_n = 1'b0; b_lo = 0; b_hi = 0; b_hold = 2;
    #1;
    check_all("R1 R2");   // B zero before any edge, A unchanged
    step("R1");
    clr_n = 1'b1;
    for (int i = 0; i < 4; i++) step("R2");
  endtask

  task automatic t_illegal();
    load_n = 1'b0; din_lo = 4'd10; din_hi = 4'd0;
    en_p = 1'b1; en_t_in = 1'b1;
    step("R9");
    load_n = 1'b1;
    for (int i = 0; i < 14; i++) step("R8 R9");
  endtask

  task automatic t_midload();
    for (int i = 0; i < 20; i++) step("R10");
    load_n = 1'b0; din_lo = 4'd7; din_hi = 4'd3;
    step("R3 R10");
    load_n = 1'b1;
    for (int i = 0; i < 40; i++) step("R10");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_long_count();
    t_enables();
    t_priority();
    t_async();
    t_illegal();
    t_midload();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule